// File: doc/BRIEF.md
# Dual-Port Hardware Token Flags

This block holds eight hardware token flags shared by two requesters, port A and port B. Each flag works as a lock that only one port can hold at a time. A port asks for a flag by writing a 0 and gives it up by writing a 1. When a port reads a flag, the flag's state as seen from that port is copied onto every bit of a 16-bit read word. A 0 means the reading port holds the token. A 1 means it does not.

If a port asks for a flag while the other port holds it, the request is stored rather than dropped. When the holder writes 1, the token passes straight to the waiting port. The waiting port can cancel its request by writing 1 before it is granted. If both ports ask for the same free flag in the same clock cycle, port A wins and port B's request is stored as pending.

Every access is a single-cycle register-style access, so no stream is involved and all pins are plain control and data with no valid/ready handshake. A write takes effect at the clock edge where it is presented. Reads are combinational from the stored state, so a write becomes visible to reads in the following cycle.

Top module: `flag_lock_unit`

## Requirements
- R1: The 3-bit index selects one of eight flags (0 to 7). An access to one flag never changes any other flag.
- R2: With select high, the read word is 16 copies of one view bit: 0 when the reading port holds the indexed flag, 1 otherwise. With select low, the read word is 16'hFFFF.
- R3: A write happens on a clock edge where both select and write are high. A write bit of 0 is a request and a write bit of 1 is a release. Its effect shows on reads from the next cycle.
- R4: A request to a free flag grants it: the requester reads 0x0000 and the other port reads 0xFFFF.
- R5: A request from the non-holder leaves both read views unchanged and is stored as pending.
- R6: When the holder releases with a request pending from the other port, the token passes to that port: the new holder reads 0x0000 and the former holder reads 0xFFFF.
- R7: When the holder releases with nothing pending, the flag becomes free and both ports read 0xFFFF.
- R8: A pending request is cancelled if its port writes 1 before the request is granted.
- R9: If both ports request the same free flag in the same cycle, port A is granted and port B's request becomes pending.
- R10: After reset, all eight flags are free and no request is pending.
- R11: A request from the holder has no effect. A release from a port that neither holds the flag nor has a request pending has no effect.
- R12: If the holder releases in the same cycle that the other port requests, the other port is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Port A access select |
| a_idx | input | 3 | Port A flag index |
| a_wr | input | 1 | Port A write strobe |
| a_wbit | input | 1 | Port A write value (0 request, 1 release) |
| a_rdata | output | 16 | Port A read word |
| b_sel | input | 1 | Port B access select |
| b_idx | input | 3 | Port B flag index |
| b_wr | input | 1 | Port B write strobe |
| b_wbit | input | 1 | Port B write value (0 request, 1 release) |
| b_rdata | output | 16 | Port B read word |

## Verification
The hardest state to reach is a stored pending request. It cannot be read directly, and it shows only when the holder later releases. The bench drives every flag into each of five setup states: free, held by A, held by A with B waiting, held by B, and held by B with A waiting. From each state it applies all nine same-cycle operation pairs (none, request or release on each port), both on the same flag and on neighbouring flags. It then releases from each side in turn, so that a lost or stale pending request becomes visible as a wrong handoff.

// File: rtl/flag_lock_pkg.sv
package flag_lock_pkg;
  typedef enum logic [1:0] {
    FL_FREE   = 2'd0,
    FL_HELD_A = 2'd1,
    FL_HELD_B = 2'd2
  } holder_t;
endpackage

// File: rtl/flag_lock_port_dec.sv
module flag_lock_port_dec #(
  parameter int N_FLAGS = 8,
  localparam int IDX_W = $clog2(N_FLAGS)
) (
  input  logic               sel,
  input  logic               wr,
  input  logic               wbit,
  input  logic [IDX_W-1:0]   idx,
  output logic [N_FLAGS-1:0] req,
  output logic [N_FLAGS-1:0] rel
);
  logic wr_en;
  assign wr_en = sel & wr;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_dec
    assign req[g] = wr_en & ~wbit & (idx == IDX_W'(g));
    assign rel[g] = wr_en &  wbit & (idx == IDX_W'(g));
  end

  // R1, R3: a write touches at most one flag and is either a request or a release
  always_comb begin
    p_single_target_r3: assert ($onehot0(req | rel));
  end
endmodule

// File: rtl/flag_lock_cell.sv
module flag_lock_cell
  import flag_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic rel_a,
  input  logic req_b,
  input  logic rel_b,
  output logic held_a,
  output logic held_b
);
  holder_t holder_q, holder_d;
  logic    pend_a_q, pend_a_d;
  logic    pend_b_q, pend_b_d;
  logic    want_a, want_b;

  // a side still wants the flag if it asks now or waited and did not cancel
  assign want_a = req_a | (pend_a_q & ~rel_a);
  assign want_b = req_b | (pend_b_q & ~rel_b);

  always_comb begin
    holder_d = holder_q;
    pend_a_d = 1'b0;
    pend_b_d = 1'b0;
    unique case (holder_q)
      FL_FREE: begin
        if (req_a) begin
          holder_d = FL_HELD_A;
          pend_b_d = req_b;
        end else if (req_b) begin
          holder_d = FL_HELD_B;
        end
      end
      FL_HELD_A: begin
        if (rel_a) holder_d = want_b ? FL_HELD_B : FL_FREE;
        else       pend_b_d = want_b;
      end
      FL_HELD_B: begin
        if (rel_b) holder_d = want_a ? FL_HELD_A : FL_FREE;
        else       pend_a_d = want_a;
      end
      default: holder_d = FL_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holder_q <= FL_FREE;
      pend_a_q <= 1'b0;
      pend_b_q <= 1'b0;
    end else begin
      holder_q <= holder_d;
      pend_a_q <= pend_a_d;
      pend_b_q <= pend_b_d;
    end
  end

  assign held_a = (holder_q == FL_HELD_A);
  assign held_b = (holder_q == FL_HELD_B);

  p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_FREE && req_a |=> holder_q == FL_HELD_A);
  p_tie_left_r9: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_FREE && req_a && req_b |=> holder_q == FL_HELD_A && pend_b_q);
  p_keep_holder_r5: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_HELD_A && !rel_a |=> holder_q == FL_HELD_A);
  p_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_HELD_A && rel_a && pend_b_q && !rel_b |=> holder_q == FL_HELD_B);
  p_release_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_HELD_B && rel_b && !pend_a_q && !req_a |=> holder_q == FL_FREE);
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_b_q && rel_b |=> !pend_b_q);
  p_same_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    holder_q == FL_HELD_B && rel_b && req_a |=> holder_q == FL_HELD_A);
  p_pend_nonholder_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(held_a && pend_a_q) && !(held_b && pend_b_q));
endmodule

// File: rtl/flag_lock_unit.sv
module flag_lock_unit #(
  parameter int N_FLAGS = 8,
  parameter int DATA_W  = 16,
  localparam int IDX_W  = $clog2(N_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_sel,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic              a_wr,
  input  logic              a_wbit,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_sel,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic              b_wr,
  input  logic              b_wbit,
  output logic [DATA_W-1:0] b_rdata
);
  logic [N_FLAGS-1:0] req_a, rel_a, req_b, rel_b;
  logic [N_FLAGS-1:0] held_a, held_b;

  flag_lock_port_dec #(.N_FLAGS(N_FLAGS)) dec_a_i (
    .sel(a_sel), .wr(a_wr), .wbit(a_wbit), .idx(a_idx), .req(req_a), .rel(rel_a));
  flag_lock_port_dec #(.N_FLAGS(N_FLAGS)) dec_b_i (
    .sel(b_sel), .wr(b_wr), .wbit(b_wbit), .idx(b_idx), .req(req_b), .rel(rel_b));

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    flag_lock_cell cell_i (
      .clk(clk), .rst_n(rst_n),
      .req_a(req_a[g]), .rel_a(rel_a[g]),
      .req_b(req_b[g]), .rel_b(rel_b[g]),
      .held_a(held_a[g]), .held_b(held_b[g]));
  end

  // view bit is 0 for the holder, replicated across the word
  assign a_rdata = a_sel ? {DATA_W{~held_a[a_idx]}} : {DATA_W{1'b1}};
  assign b_rdata = b_sel ? {DATA_W{~held_b[b_idx]}} : {DATA_W{1'b1}};

  p_views_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    a_sel && b_sel && a_idx == b_idx |-> !(a_rdata[0] == 1'b0 && b_rdata[0] == 1'b0));
  p_word_uniform_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rdata == '0 || a_rdata == '1) && (b_rdata == '0 || b_rdata == '1));
endmodule

// File: tb/flag_lock_unit_tb_top.sv
`timescale 1ns/1ps
module flag_lock_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_sel = 0, a_wr = 0, a_wbit = 0, b_sel = 0, b_wr = 0, b_wbit = 0;
  logic [2:0] a_idx = 0, b_idx = 0;
  logic [15:0] a_rdata, b_rdata;
  int checks = 0, fails = 0;
  int own [8];
  bit pa [8], pb [8];

  always #4 clk = ~clk;

  flag_lock_unit dut_i (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int f = 0; f < 8; f++) begin
      a_sel = 1; a_idx = 3'(f); b_sel = 1; b_idx = 3'(f);
      #0.2;
      check(tag, a_rdata, own[f] == 1 ? 16'h0000 : 16'hFFFF);
      check(tag, b_rdata, own[f] == 2 ? 16'h0000 : 16'hFFFF);
    end
    a_sel = 0; b_sel = 0;
  endtask

  // op: 0 none, 1 request (write 0), 2 release (write 1)
  task automatic apply(int aop, int ai, int bop, int bi);
    @(negedge clk);
    a_sel = (aop != 0); a_wr = (aop != 0); a_wbit = (aop == 2); a_idx = 3'(ai);
    b_sel = (bop != 0); b_wr = (bop != 0); b_wbit = (bop == 2); b_idx = 3'(bi);
    for (int f = 0; f < 8; f++) begin
      bit ra = (aop == 1 && ai == f), la = (aop == 2 && ai == f);
      bit rb = (bop == 1 && bi == f), lb = (bop == 2 && bi == f);
      bit wa = ra || (pa[f] && !la), wb = rb || (pb[f] && !lb);
      if (own[f] == 0) begin
        if (ra) begin own[f] = 1; pb[f] = rb; end
        else if (rb) own[f] = 2;
      end else if (own[f] == 1) begin
        if (la) begin own[f] = wb ? 2 : 0; pb[f] = 0; end
        else pb[f] = wb;
      end else begin
        if (lb) begin own[f] = wa ? 1 : 0; pa[f] = 0; end
        else pa[f] = wa;
      end
    end
    @(posedge clk); #1;
    a_sel = 0; a_wr = 0; b_sel = 0; b_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int f = 0; f < 8; f++) begin own[f] = 0; pa[f] = 0; pb[f] = 0; end
    #1;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R10");
    #0.2; check("R2", a_rdata, 16'hFFFF); check("R2", b_rdata, 16'hFFFF);
    apply(1, 3, 0, 0); check_all("R4");
    #0.2; check("R2", a_rdata, 16'hFFFF);
    apply(0, 0, 1, 3); check_all("R5");
    apply(2, 3, 0, 0); check_all("R6");
    apply(1, 3, 0, 0); apply(2, 3, 0, 0); apply(0, 0, 2, 3); check_all("R8");
    apply(1, 5, 1, 5); check_all("R9");
    apply(2, 5, 0, 0); check_all("R9");
    apply(1, 5, 2, 5); check_all("R12");
    apply(1, 5, 0, 0); apply(0, 0, 2, 5); check_all("R11");
    apply(2, 5, 0, 0); check_all("R7");
    apply(1, 0, 1, 7); check_all("R1");
    // R3: write strobe without select is ignored
    @(negedge clk); a_wr = 1; a_wbit = 0; a_idx = 3'd2; @(posedge clk); #1; a_wr = 0;
    check_all("R3");

    for (int f = 0; f < 8; f++)
      for (int same = 0; same < 2; same++)
        for (int s = 0; s < 5; s++)
          for (int aop = 0; aop < 3; aop++)
            for (int bop = 0; bop < 3; bop++) begin
              int bi = same ? f : (f + 1) % 8;
              do_reset();
              case (s)
                1: apply(1, f, 0, 0);
                2: begin apply(1, f, 0, 0); apply(0, 0, 1, f); end
                3: apply(0, 0, 1, f);
                4: begin apply(0, 0, 1, f); apply(1, f, 0, 0); end
                default: ;
              endcase
              apply(aop, f, bop, bi); check_all("R3");
              apply(2, f, 0, 0);      check_all("R6");
              apply(0, 0, 2, f);      check_all("R7");
              apply(0, 0, 2, bi);     check_all("R1");
            end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule